// File: doc/BRIEF.md
# UART Task and Event Register Controller

This block is the register front end of a simple UART. Software talks to it through word-addressed 32-bit reads and writes. It starts and stops the receiver and the transmitter through task registers. It watches progress through sticky event registers, and it clears those registers itself. Four events are tracked: receive data ready, transmit data ready, line error and receive timeout. Each event has an enable bit, and the enabled events are combined into one registered interrupt line. The interrupt-enable register can be replaced, have bits set, or have bits cleared, each through its own address.

The serial shifter, baud generator and pin routing sit outside this block and are reached through byte-wide ports.

- **Receive side.** A small circular FIFO collects incoming bytes while reception runs. Reading the receive-data word pops the head byte.
- **Transmit side.** A transmit-data write hands one byte to the shifter. The block then waits for a done pulse.
- **Line error.** A line-break input sets two error-source bits. Software clears them by writing ones.
- **Global enable.** A global enable word gates every other register write.

The transmit channel is a four-state machine:
- `TX_OFF`: stopped, nothing pending.
- `TX_IDLE`: started, nothing pending.
- `TX_BUSY`: started, byte pending.
- `TX_DRAIN`: stopped, byte still pending.

Its transitions are:
- start: `TX_OFF`→`TX_IDLE`, `TX_DRAIN`→`TX_BUSY`.
- stop: `TX_IDLE`→`TX_OFF`, `TX_BUSY`→`TX_DRAIN`.
- accept: `TX_IDLE`→`TX_BUSY`.
- done: `TX_BUSY`→`TX_IDLE`, `TX_DRAIN`→`TX_OFF`.

The receive channel has two states, `RX_OFF` and `RX_ON`, with a start transition (`RX_OFF`→`RX_ON`) and a stop transition (`RX_ON`→`RX_OFF`).

Top module: `uart_evt_ctrl`

Word map (the index is the value on `bus_addr`):

| Index | Word |
|---|---|
| 0 | receive start task |
| 1 | receive stop task |
| 2 | transmit start task |
| 3 | transmit stop task |
| 4 | RX-ready event |
| 5 | TX-ready event |
| 6 | error event |
| 7 | RX-timeout event |
| 8 | interrupt enable |
| 9 | interrupt-enable set alias |
| 10 | interrupt-enable clear alias |
| 11 | error source |
| 12 | global enable |
| 13–16 | pin selects |
| 17 | baud word |
| 18 | receive data |
| 19 | transmit data |

Task words and unused indices read 0.

## Requirements
- R1: `irq` goes high one cycle after any event whose enable bit is set becomes 1. It is the registered OR of each event ANDed with its enable bit. The enable bits are: bit 0 for RX-ready, bit 1 for TX-ready, bit 2 for error, bit 3 for RX-timeout.
- R2: A write to index 8 replaces the interrupt-enable word. A write to index 9 ORs the data into it. A write to index 10 clears every bit that is 1 in the data. Indices 8, 9 and 10 all read back the enable word.
- R3: The error-source word (index 11) is write-one-to-clear: each 1 in the written data clears the matching stored bit, and the other bits are kept.
- R4: While the global enable word (index 12) is zero, every write to any other index has no effect. The enable word itself is always writable, and any nonzero value enables the block.
- R5: A write to index 19 is accepted only when transmission is started and no byte is pending. An accepted write drives `tx_valid` high, with the byte on `tx_data`. A `tx_done` pulse while a byte is pending drops `tx_valid` and sets the TX-ready event.
- R6: A read of index 18 returns the FIFO head byte in the low 8 bits. If reception is started and the FIFO is not empty, the read pops the head. When bytes remain after the pop, the RX-ready event is set again.
- R7: A task word fires when its data bit 0 is 1. The receive stop task clears the receive started flag and sets the RX-timeout event. The transmit start and stop tasks set and clear the transmit started flag.
- R8: An `rx_valid` byte is stored only while reception is started and the FIFO holds fewer than `FIFO_DEPTH` bytes. A stored byte sets RX-ready. Bytes come out in arrival order across pointer wrap.
- R9: A `line_break` pulse ORs 3 into the error-source word and sets the error event.
- R10: After reset, the four pin-select words read all ones and the baud word reads 0x04000000. Every other word, `irq` and `tx_valid` read 0.
- R11: A write to an event index (4 to 7) stores 1 if the data is nonzero and 0 otherwise. A read returns that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| bus_wr | input | 1 | register write strobe |
| bus_rd | input | 1 | register read strobe (pops the FIFO on index 18) |
| bus_addr | input | 5 | word index |
| bus_wdata | input | DATA_W | write data |
| bus_rdata | output | DATA_W | read data, combinational from `bus_addr` |
| rx_valid | input | 1 | incoming byte strobe |
| rx_data | input | BYTE_W | incoming byte |
| line_break | input | 1 | break detected on the line |
| tx_valid | output | 1 | a transmit byte is pending |
| tx_data | output | BYTE_W | pending transmit byte |
| tx_done | input | 1 | shifter finished the pending byte |
| irq | output | 1 | level interrupt |

## Verification
The bench builds the block with `FIFO_DEPTH` set to 4 instead of 6. With that depth, the directed receive sequence reaches the full condition with a single burst and drops the overflow byte. It also moves the head pointer far enough that the next stored byte wraps to slot zero. In the random phase, at the same depth, full-FIFO rejection and wrapped reads happen many times rather than rarely.

// File: rtl/uart_evt_pkg.sv
package uart_evt_pkg;

    localparam int REG_AW = 5;
    localparam int N_EV   = 4;
    localparam int N_PIN  = 4;

    localparam int EV_RX = 0;
    localparam int EV_TX = 1;
    localparam int EV_ER = 2;
    localparam int EV_TO = 3;

    typedef enum logic [REG_AW-1:0] {
        REG_RX_GO    = 5'd0,
        REG_RX_HALT  = 5'd1,
        REG_TX_GO    = 5'd2,
        REG_TX_HALT  = 5'd3,
        REG_EV_RXRDY = 5'd4,
        REG_EV_TXRDY = 5'd5,
        REG_EV_ERR   = 5'd6,
        REG_EV_RXTO  = 5'd7,
        REG_IEN      = 5'd8,
        REG_IEN_SET  = 5'd9,
        REG_IEN_CLR  = 5'd10,
        REG_ERRSRC   = 5'd11,
        REG_ENABLE   = 5'd12,
        REG_PIN0     = 5'd13,
        REG_PIN1     = 5'd14,
        REG_PIN2     = 5'd15,
        REG_PIN3     = 5'd16,
        REG_BAUD     = 5'd17,
        REG_RXDATA   = 5'd18,
        REG_TXDATA   = 5'd19
    } reg_e;

    localparam logic [REG_AW-1:0] EV_BASE  = 5'd4;
    localparam logic [REG_AW-1:0] PIN_BASE = 5'd13;

    typedef enum logic [1:0] {
        TX_OFF   = 2'd0,
        TX_IDLE  = 2'd1,
        TX_BUSY  = 2'd2,
        TX_DRAIN = 2'd3
    } tx_state_e;

    typedef enum logic {
        RX_OFF = 1'b0,
        RX_ON  = 1'b1
    } rx_state_e;

endpackage

// File: rtl/uart_evt_txfsm.sv
module uart_evt_txfsm
    import uart_evt_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              stop_req,
    input  logic              load_req,
    input  logic [BYTE_W-1:0] load_byte,
    input  logic              done_in,
    output logic              busy_o,
    output logic              finished_o,
    output logic [BYTE_W-1:0] byte_o
);

    tx_state_e         state_q, state_d;
    logic [BYTE_W-1:0] byte_q;
    logic              accepted;

    assign accepted   = (state_q == TX_IDLE) && load_req && !stop_req;
    assign finished_o = done_in && ((state_q == TX_BUSY) || (state_q == TX_DRAIN));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_OFF: begin
                if (start_req) state_d = TX_IDLE;
            end
            TX_IDLE: begin
                if (stop_req)      state_d = TX_OFF;
                else if (load_req) state_d = TX_BUSY;
            end
            TX_BUSY: begin
                if (done_in)       state_d = stop_req ? TX_OFF : TX_IDLE;
                else if (stop_req) state_d = TX_DRAIN;
            end
            TX_DRAIN: begin
                if (done_in)        state_d = start_req ? TX_IDLE : TX_OFF;
                else if (start_req) state_d = TX_BUSY;
            end
            default: state_d = TX_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        byte_q <= '0;
        else if (accepted) byte_q <= load_byte;
    end

    assign busy_o = (state_q == TX_BUSY) || (state_q == TX_DRAIN);
    assign byte_o = byte_q;

    AST_TX_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (finished_o && !start_req) |=> !busy_o); // R5
    AST_TX_BYTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !finished_o) |=> $stable(byte_o)); // R5

endmodule

// File: rtl/uart_evt_rxpath.sv
module uart_evt_rxpath
    import uart_evt_pkg::*;
#(
    parameter int DEPTH  = 6,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              stop_req,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              pop_req,
    output logic              push_ok,
    output logic              pop_ok,
    output logic              more_left,
    output logic [BYTE_W-1:0] head_byte
);

    localparam int CW    = $clog2(DEPTH + 1);
    localparam int MEM_N = 1 << CW;
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [CW-1:0] LAST_C  = CW'(DEPTH - 1);
    localparam logic [CW-1:0] ONE_C   = CW'(1);

    rx_state_e         state_q, state_d;
    logic [BYTE_W-1:0] mem_q [MEM_N];
    logic [CW-1:0]     head_q, len_q, head_d, len_d, wpos;
    logic [CW:0]       sum;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_OFF:  if (start_req) state_d = RX_ON;
            RX_ON:   if (stop_req)  state_d = RX_OFF;
            default: state_d = RX_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_OFF;
        else        state_q <= state_d;
    end

    assign push_ok   = in_valid && (state_q == RX_ON) && (len_q < DEPTH_C);
    assign pop_ok    = pop_req && (state_q == RX_ON) && (len_q != '0);
    assign more_left = len_q > ONE_C;
    assign head_byte = mem_q[head_q];

    assign sum  = {1'b0, head_q} + {1'b0, len_q};
    assign wpos = (sum >= {1'b0, DEPTH_C}) ? CW'(sum - {1'b0, DEPTH_C}) : sum[CW-1:0];

    always_comb begin
        head_d = head_q;
        if (pop_ok) head_d = (head_q == LAST_C) ? '0 : head_q + ONE_C;
        len_d = len_q + CW'(push_ok) - CW'(pop_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= '0;
            len_q  <= '0;
        end else begin
            head_q <= head_d;
            len_q  <= len_d;
        end
    end

    generate
        for (genvar g = 0; g < MEM_N; g++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                                  mem_q[g] <= '0;
                else if (push_ok && (wpos == CW'(g)))        mem_q[g] <= in_byte;
            end
        end
    endgenerate

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        len_q <= DEPTH_C); // R8
    AST_FULL_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        (len_q == DEPTH_C && !pop_req) |=> (len_q == DEPTH_C)); // R8
    AST_OFF_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_OFF) |=> $stable(head_q)); // R6

endmodule

// File: rtl/uart_evt_irq.sv
module uart_evt_irq #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev,
    input  logic [N-1:0] en,
    output logic         irq_o
);

    logic [N-1:0] term;
    logic         irq_q;

    generate
        for (genvar g = 0; g < N; g++) begin : g_term
            assign term[g] = ev[g] & en[g];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |term;
    end

    assign irq_o = irq_q;

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |=> !irq_o); // R1

endmodule

// File: rtl/uart_evt_ctrl.sv
module uart_evt_ctrl
    import uart_evt_pkg::*;
#(
    parameter int FIFO_DEPTH = 6,
    parameter int DATA_W     = 32,
    parameter int BYTE_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              line_break,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              tx_done,
    output logic              irq
);

    localparam logic [DATA_W-1:0] PIN_RST  = '1;
    localparam logic [DATA_W-1:0] BAUD_RST = DATA_W'(32'h0400_0000);
    localparam logic [DATA_W-1:0] BRK_BITS = DATA_W'(3);

    reg_e              addr_e;
    logic              wr_ok;
    logic [N_EV-1:0]   ev_q, ev_d;
    logic [DATA_W-1:0] ien_q, ien_d, err_q, err_d, en_q, baud_q;
    logic [DATA_W-1:0] pin_q [N_PIN];
    logic              rx_go, rx_halt, tx_go, tx_halt, tx_load, rx_pop;
    logic              push_ok, pop_ok, more_left, tx_fin;
    logic [BYTE_W-1:0] head_byte;

    assign addr_e  = reg_e'(bus_addr);
    assign wr_ok   = bus_wr && ((en_q != '0) || (addr_e == REG_ENABLE));
    assign rx_go   = wr_ok && (addr_e == REG_RX_GO)   && bus_wdata[0];
    assign rx_halt = wr_ok && (addr_e == REG_RX_HALT) && bus_wdata[0];
    assign tx_go   = wr_ok && (addr_e == REG_TX_GO)   && bus_wdata[0];
    assign tx_halt = wr_ok && (addr_e == REG_TX_HALT) && bus_wdata[0];
    assign tx_load = wr_ok && (addr_e == REG_TXDATA);
    assign rx_pop  = bus_rd && (addr_e == REG_RXDATA);

    uart_evt_rxpath #(.DEPTH(FIFO_DEPTH), .BYTE_W(BYTE_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (rx_go),
        .stop_req  (rx_halt),
        .in_valid  (rx_valid),
        .in_byte   (rx_data),
        .pop_req   (rx_pop),
        .push_ok   (push_ok),
        .pop_ok    (pop_ok),
        .more_left (more_left),
        .head_byte (head_byte)
    );

    uart_evt_txfsm #(.BYTE_W(BYTE_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_req  (tx_go),
        .stop_req   (tx_halt),
        .load_req   (tx_load),
        .load_byte  (bus_wdata[BYTE_W-1:0]),
        .done_in    (tx_done),
        .busy_o     (tx_valid),
        .finished_o (tx_fin),
        .byte_o     (tx_data)
    );

    uart_evt_irq #(.N(N_EV)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .ev    (ev_q),
        .en    (ien_q[N_EV-1:0]),
        .irq_o (irq)
    );

    // Bus writes land first, hardware-raised events override them.
    always_comb begin
        ev_d = ev_q;
        for (int i = 0; i < N_EV; i++) begin
            if (wr_ok && (bus_addr == EV_BASE + REG_AW'(i))) ev_d[i] = |bus_wdata;
        end
        if (rx_halt)                ev_d[EV_TO] = 1'b1;
        if (push_ok)                ev_d[EV_RX] = 1'b1;
        if (pop_ok && more_left)    ev_d[EV_RX] = 1'b1;
        if (tx_fin)                 ev_d[EV_TX] = 1'b1;
        if (line_break)             ev_d[EV_ER] = 1'b1;
    end

    always_comb begin
        ien_d = ien_q;
        if (wr_ok) begin
            unique case (addr_e)
                REG_IEN:     ien_d = bus_wdata;
                REG_IEN_SET: ien_d = ien_q | bus_wdata;
                REG_IEN_CLR: ien_d = ien_q & ~bus_wdata;
                default:     ien_d = ien_q;
            endcase
        end
        err_d = err_q;
        if (wr_ok && (addr_e == REG_ERRSRC)) err_d = err_q & ~bus_wdata;
        if (line_break)                      err_d = err_d | BRK_BITS;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_q  <= '0;
            ien_q <= '0;
            err_q <= '0;
        end else begin
            ev_q  <= ev_d;
            ien_q <= ien_d;
            err_q <= err_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               en_q <= '0;
        else if (bus_wr && addr_e == REG_ENABLE)  en_q <= bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              baud_q <= BAUD_RST;
        else if (wr_ok && addr_e == REG_BAUD)    baud_q <= bus_wdata;
    end

    generate
        for (genvar g = 0; g < N_PIN; g++) begin : g_pin
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pin_q[g] <= PIN_RST;
                else if (wr_ok && (bus_addr == PIN_BASE + REG_AW'(g))) pin_q[g] <= bus_wdata;
            end
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        case (addr_e)
            REG_EV_RXRDY: bus_rdata = DATA_W'(ev_q[EV_RX]);
            REG_EV_TXRDY: bus_rdata = DATA_W'(ev_q[EV_TX]);
            REG_EV_ERR:   bus_rdata = DATA_W'(ev_q[EV_ER]);
            REG_EV_RXTO:  bus_rdata = DATA_W'(ev_q[EV_TO]);
            REG_IEN, REG_IEN_SET, REG_IEN_CLR: bus_rdata = ien_q;
            REG_ERRSRC:   bus_rdata = err_q;
            REG_ENABLE:   bus_rdata = en_q;
            REG_PIN0:     bus_rdata = pin_q[0];
            REG_PIN1:     bus_rdata = pin_q[1];
            REG_PIN2:     bus_rdata = pin_q[2];
            REG_PIN3:     bus_rdata = pin_q[3];
            REG_BAUD:     bus_rdata = baud_q;
            REG_RXDATA:   bus_rdata = DATA_W'(head_byte);
            REG_TXDATA:   bus_rdata = DATA_W'(tx_data);
            default:      bus_rdata = '0;
        endcase
    end

    AST_IEN_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && addr_e == REG_IEN_SET) |=> ((ien_q & $past(bus_wdata)) == $past(bus_wdata))); // R2
    AST_DISABLED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && en_q == '0 && addr_e != REG_ENABLE && !line_break)
        |=> ($stable(ien_q) && $stable(err_q) && $stable(baud_q))); // R4
    AST_STOP_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
        rx_halt |=> ev_q[EV_TO]); // R7
    AST_BREAK_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        line_break |=> (ev_q[EV_ER] && err_q[1:0] == 2'b11)); // R9

endmodule

// File: tb/sim_uart_evt_ctrl.sv
module sim_uart_evt_ctrl;
    import uart_evt_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        rx_valid = 1'b0, line_break = 1'b0, tx_done = 1'b0;
    logic [7:0]  rx_data = '0, tx_data;
    logic        tx_valid, irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_evt_ctrl #(.FIFO_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .line_break(line_break),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_done(tx_done), .irq(irq)
    );

    int checks = 0, errors = 0;
    bit done_flag = 0;

    logic [3:0]  m_ev;
    logic [31:0] m_ien, m_err, m_en, m_baud;
    logic [31:0] m_pin [4];
    bit          m_rxon, m_txon, m_pend;
    logic [7:0]  m_txb;
    logic [7:0]  m_q [$];

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void m_reset();
        m_ev = '0; m_ien = '0; m_err = '0; m_en = '0;
        m_baud = 32'h0400_0000;
        for (int i = 0; i < 4; i++) m_pin[i] = '1;
        m_rxon = 0; m_txon = 0; m_pend = 0; m_txb = '0;
        m_q.delete();
    endfunction

    function automatic logic m_irq();
        return |(m_ev & m_ien[3:0]);
    endfunction

    function automatic logic [31:0] m_read(logic [4:0] a);
        case (a)
            5'd4, 5'd5, 5'd6, 5'd7: return {31'b0, m_ev[a-5'd4]};
            5'd8, 5'd9, 5'd10:      return m_ien;
            5'd11:                  return m_err;
            5'd12:                  return m_en;
            5'd13, 5'd14, 5'd15, 5'd16: return m_pin[a-5'd13];
            5'd17:                  return m_baud;
            5'd18:                  return (m_q.size() > 0) ? {24'b0, m_q[0]} : 32'b0;
            5'd19:                  return {24'b0, m_txb};
            default:                return 32'b0;
        endcase
    endfunction

    function automatic void m_write(logic [4:0] a, logic [31:0] w);
        if (m_en == 0 && a != 5'd12) return;
        case (a)
            5'd0: if (w[0]) m_rxon = 1;
            5'd1: if (w[0]) begin m_rxon = 0; m_ev[3] = 1; end
            5'd2: if (w[0]) m_txon = 1;
            5'd3: if (w[0]) m_txon = 0;
            5'd4, 5'd5, 5'd6, 5'd7: m_ev[a-5'd4] = (w != 0);
            5'd8:  m_ien = w;
            5'd9:  m_ien = m_ien | w;
            5'd10: m_ien = m_ien & ~w;
            5'd11: m_err = m_err & ~w;
            5'd12: m_en = w;
            5'd13, 5'd14, 5'd15, 5'd16: m_pin[a-5'd13] = w;
            5'd17: m_baud = w;
            5'd19: if (m_txon && !m_pend) begin m_pend = 1; m_txb = w[7:0]; end
            default: ;
        endcase
    endfunction

    task automatic bus_write(logic [4:0] a, logic [31:0] w);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = w;
        @(posedge clk); #1;
        bus_wr = 0;
        m_write(a, w);
    endtask

    task automatic bus_read(logic [4:0] a, string req);
        @(negedge clk);
        bus_rd = 1; bus_addr = a;
        #1;
        if (!(a == 5'd18 && m_q.size() == 0)) check(req, bus_rdata, m_read(a));
        @(posedge clk); #1;
        bus_rd = 0;
        if (a == 5'd18 && m_rxon && m_q.size() > 0) begin
            void'(m_q.pop_front());
            if (m_q.size() > 0) m_ev[0] = 1;
        end
    endtask

    task automatic push_byte(logic [7:0] b);
        @(negedge clk);
        rx_valid = 1; rx_data = b;
        @(posedge clk); #1;
        rx_valid = 0;
        if (m_rxon && m_q.size() < DEPTH) begin
            m_q.push_back(b);
            m_ev[0] = 1;
        end
    endtask

    task automatic send_break();
        @(negedge clk);
        line_break = 1;
        @(posedge clk); #1;
        line_break = 0;
        m_err = m_err | 32'd3;
        m_ev[2] = 1;
    endtask

    task automatic send_done();
        @(negedge clk);
        tx_done = 1;
        @(posedge clk); #1;
        tx_done = 0;
        if (m_pend) begin m_pend = 0; m_ev[1] = 1; end
    endtask

    task automatic check_outs(string req);
        @(posedge clk); #1;
        check({req, " R1 irq"}, {31'b0, irq}, {31'b0, m_irq()});
        check({req, " R5 tx_valid"}, {31'b0, tx_valid}, {31'b0, m_pend});
        if (m_pend) check({req, " R5 tx_data"}, {24'b0, tx_data}, {24'b0, m_txb});
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R10: reset values of every word
        for (int a = 0; a < 20; a++) bus_read(5'(a), "R10 reset word");
        check_outs("R10 reset outs");

        // R4: disabled block ignores writes
        bus_write(5'd8, 32'hF);
        bus_write(5'd0, 32'd1);
        push_byte(8'hAA);
        bus_read(5'd8, "R4 ien unchanged");
        bus_read(5'd4, "R4 rx not started");
        bus_write(5'd12, 32'd1);
        bus_read(5'd12, "R4 enable written");

        // R2: enable aliases
        bus_write(5'd8, 32'h5);
        bus_write(5'd9, 32'hA);
        bus_read(5'd9, "R2 set alias");
        bus_write(5'd10, 32'h3);
        bus_read(5'd10, "R2 clear alias");
        bus_read(5'd8, "R2 ien value");

        // R11: event writes
        bus_write(5'd5, 32'd7);
        bus_read(5'd5, "R11 nonzero sets");
        bus_write(5'd5, 32'd0);
        bus_read(5'd5, "R11 zero clears");

        // R9 and R3: break then write-one-to-clear
        send_break();
        bus_read(5'd11, "R9 error source");
        bus_read(5'd6, "R9 error event");
        check_outs("R9 irq");
        bus_write(5'd11, 32'd1);
        bus_read(5'd11, "R3 w1c keeps bit1");
        bus_write(5'd6, 32'd0);

        // R8 and R6: fill, overflow, pop, wrap
        bus_write(5'd0, 32'd1);
        push_byte(8'h11); push_byte(8'h22); push_byte(8'h33);
        push_byte(8'h44); push_byte(8'h55);
        bus_read(5'd4, "R8 rx ready set");
        bus_write(5'd4, 32'd0);
        bus_read(5'd18, "R6 first byte");
        bus_read(5'd4, "R6 ready re-raised");
        push_byte(8'h66);
        bus_read(5'd18, "R8 order");
        bus_read(5'd18, "R8 order");
        bus_read(5'd18, "R8 order");
        bus_write(5'd4, 32'd0);
        bus_read(5'd18, "R8 wrapped byte");
        bus_read(5'd4, "R6 last pop no ready");

        // R7: stop raises timeout, later bytes dropped
        bus_write(5'd8, 32'h8);
        bus_write(5'd1, 32'd1);
        bus_read(5'd7, "R7 timeout event");
        check_outs("R7 irq");
        push_byte(8'h77);
        bus_read(5'd4, "R7 stopped no push");

        // R5: transmit handshake
        bus_write(5'd19, 32'h41);
        check_outs("R5 not started");
        bus_write(5'd2, 32'd1);
        bus_write(5'd19, 32'h42);
        check_outs("R5 accepted");
        bus_write(5'd19, 32'h43);
        check_outs("R5 second ignored");
        send_done();
        bus_read(5'd5, "R5 tx ready");
        check_outs("R5 done");

        // random phase
        for (int n = 0; n < 800; n++) begin
            int r;
            logic [4:0] a;
            logic [31:0] w;
            r = $urandom % 100;
            a = 5'($urandom % 20);
            if (r < 35) begin
                if (a <= 5'd3)       w = $urandom % 2;
                else if (a == 5'd12) w = ($urandom % 8 == 0) ? 32'd0 : 32'd1;
                else if (a <= 5'd7)  w = $urandom % 3;
                else                 w = $urandom;
                bus_write(a, w);
            end else if (r < 60) begin
                bus_read(a, "R6 R11 random read");
            end else if (r < 85) begin
                push_byte(8'($urandom));
            end else if (r < 90) begin
                send_break();
            end else begin
                send_done();
            end
            check_outs("random");
        end

        finish_run();
    end

endmodule